// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Collector

This block sits behind an ingress port that has already turned inbound message-signalled interrupt writes into a plain address/data pair. When such a write targets the programmed 64-bit capture address, the data word names one of 64 vectors. The block records that vector as pending in a status bank, where software later reads and clears it.

The 64 vectors form two 32-bit banks. Each bank has its own pending register, its own enable mask and its own interrupt line toward the processor. Software programs the block through a small word-addressed register port. Writes take effect on the clock edge. Reads return data combinationally for the selected word.

The register words are numbered by `reg_sel`:

| Word | Contents |
|------|----------|
| 0 | presence flag |
| 1 | control |
| 2 | low base |
| 3 | high base |
| 4 | low pending |
| 5 | high pending |
| 6 | low mask |
| 7 | high mask |

Top module: `msi_vector_collector`

## Requirements
- R1: After reset, words 1 to 7 read zero and both interrupt lines are low. Word 0 (presence flag) always reads 0x00000001.
- R2: A qualifying inbound write whose data is v (0 to 63) sets pending bit v. Bits 0 to 31 appear in word 4 at position v, and bits 32 to 63 appear in word 5 at position v-32. The bit reads back set from the first clock edge that samples the write.
- R3: An inbound write whose 64-bit address differs from {word 3, word 2} in any bit leaves both pending words unchanged.
- R4: A write is captured only when control bit 0 (capture enable) and control bit 15 (report enable) are both 1. If either is 0, the pending words are unchanged.
- R5: An inbound write whose 32-bit data value is 64 or larger is ignored, even when its low six bits name a valid vector.
- R6: Writing a 1 to a bit of word 4 or word 5 clears that pending bit. Writing a 0 leaves the bit as it is.
- R7: `irq_lo` is high exactly when some bit is set in both word 4 and word 6. `irq_hi` is high exactly when some bit is set in both word 5 and word 7. Both lines follow the registers with no further delay.
- R8: Clearing a mask bit blocks that vector from its interrupt line but keeps its pending bit.
- R9: When a capture and a software clear hit the same pending bit in one cycle, the bit ends up set. A clear of a different bit in that cycle still takes effect.
- R10: Words 2, 3, 6 and 7 read back what was written. Word 1 keeps only bits 0 and 15 and reads zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound interrupt write present this cycle |
| msg_addr | input | 64 | Target address of the inbound write |
| msg_data | input | 32 | Data of the inbound write (vector number) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| irq_lo | output | 1 | Interrupt for vectors 0 to 31 |
| irq_hi | output | 1 | Interrupt for vectors 32 to 63 |

## Verification
Every inbound write and register write is sampled on a single rising edge. Its effect on the pending words is due right after that same edge. The interrupt lines are combinational from the registers, so they carry no extra cycle of delay.

The bench drives each stimulus on the falling edge and holds it over exactly one rising edge. It then reads the register port and the interrupt lines one nanosecond later, so every comparison sees the state produced by that one edge.

The bench sweeps all 64 vectors and flips each of the 64 address bits. It also tries every combination of the two enable bits, and drives captures and clears in the same cycle.

// File: rtl/msi_vector_collector.sv
module msi_vector_collector (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_valid,
  input  logic [63:0] msg_addr,
  input  logic [31:0] msg_data,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_lo,
  output logic        irq_hi
);
  localparam logic [2:0] SEL_PRESENT = 3'd0;
  localparam logic [2:0] SEL_CTRL    = 3'd1;
  localparam logic [2:0] SEL_BASE_LO = 3'd2;
  localparam logic [2:0] SEL_BASE_HI = 3'd3;
  localparam logic [2:0] SEL_PEND_LO = 3'd4;
  localparam logic [2:0] SEL_PEND_HI = 3'd5;
  localparam logic [2:0] SEL_MASK_LO = 3'd6;
  localparam logic [2:0] SEL_MASK_HI = 3'd7;

  logic        cap_en, rep_en;
  logic [63:0] base, pend, mask;
  logic        cap_ok;
  logic [63:0] set_vec, clr_vec;

  assign cap_ok  = msg_valid && cap_en && rep_en && (msg_addr == base) && (msg_data < 32'd64);
  assign set_vec = cap_ok ? (64'd1 << msg_data[5:0]) : 64'd0;
  assign clr_vec = !reg_wr                  ? 64'd0 :
                   (reg_sel == SEL_PEND_LO) ? {32'd0, reg_wdata} :
                   (reg_sel == SEL_PEND_HI) ? {reg_wdata, 32'd0} : 64'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_en <= 1'b0;
      rep_en <= 1'b0;
      base   <= '0;
      mask   <= '0;
      pend   <= '0;
    end else begin
      pend <= (pend & ~clr_vec) | set_vec;
      if (reg_wr) begin
        case (reg_sel)
          SEL_CTRL:    begin cap_en <= reg_wdata[0]; rep_en <= reg_wdata[15]; end
          SEL_BASE_LO: base[31:0]  <= reg_wdata;
          SEL_BASE_HI: base[63:32] <= reg_wdata;
          SEL_MASK_LO: mask[31:0]  <= reg_wdata;
          SEL_MASK_HI: mask[63:32] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_PRESENT: reg_rdata = 32'd1;
      SEL_CTRL:    reg_rdata = {16'd0, rep_en, 14'd0, cap_en};
      SEL_BASE_LO: reg_rdata = base[31:0];
      SEL_BASE_HI: reg_rdata = base[63:32];
      SEL_PEND_LO: reg_rdata = pend[31:0];
      SEL_PEND_HI: reg_rdata = pend[63:32];
      SEL_MASK_LO: reg_rdata = mask[31:0];
      default:     reg_rdata = mask[63:32];
    endcase
  end

  assign irq_lo = |(pend[31:0] & mask[31:0]);
  assign irq_hi = |(pend[63:32] & mask[63:32]);

  assert_present_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_PRESENT) |-> (reg_rdata == 32'd1));

  assert_capture_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ok |=> pend[$past(msg_data[5:0])]);

  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ok |=> ((pend & ~$past(pend)) == 64'd0));

  assert_clear_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_PEND_LO && !cap_ok) |=> ((pend[31:0] & $past(reg_wdata)) == 32'd0));

  assert_irq_lo_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (pend[31:0] != 32'd0));

  assert_irq_hi_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (pend[63:32] != 32'd0));

  assert_mask_keeps_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == SEL_MASK_LO || reg_sel == SEL_MASK_HI)) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/msi_vector_collector_bench.sv
`timescale 1ns/1ps
module msi_vector_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] BASE = 64'h0000_00A5_1000_0040;

  always #10 clk = ~clk;

  msi_vector_collector u_msi_vector_collector (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit mv, input logic [63:0] a, input logic [31:0] d,
                      input bit wr, input logic [2:0] sel, input logic [31:0] wd);
    @(negedge clk);
    msg_valid = mv; msg_addr = a; msg_data = d;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    #1;
    msg_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] wd);
    step(1'b0, '0, '0, 1'b1, sel, wd);
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 3'd0, '0);
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic pend_is(input string req, input logic [63:0] exp);
    logic [31:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd5, hi);
    chk(req, lo, exp[31:0]);
    chk(req, hi, exp[63:32]);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk("R1 presence", d, 32'd1);
    for (int s = 1; s < 8; s++) begin
      rd(s[2:0], d); chk("R1 reset word", d, 32'd0);
    end
    chk("R1 irq_lo", {31'd0, irq_lo}, 32'd0);
    chk("R1 irq_hi", {31'd0, irq_hi}, 32'd0);

    // R10 register readback
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R10 control", d, 32'h0000_8001);
    wr_reg(3'd2, BASE[31:0]);
    wr_reg(3'd3, BASE[63:32]);
    rd(3'd2, d); chk("R10 base lo", d, BASE[31:0]);
    rd(3'd3, d); chk("R10 base hi", d, BASE[63:32]);
    wr_reg(3'd6, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R10 mask lo", d, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R10 mask hi", d, 32'hFFFF_FFFF);

    // R2 / R7 / R6 sweep of every vector
    for (int v = 0; v < 64; v++) begin
      send(BASE, v);
      pend_is("R2 capture", 64'd1 << v);
      chk("R7 irq_lo", {31'd0, irq_lo}, {31'd0, v < 32});
      chk("R7 irq_hi", {31'd0, irq_hi}, {31'd0, v >= 32});
      wr_reg(v < 32 ? 3'd4 : 3'd5, ~(32'd1 << (v % 32)));
      pend_is("R6 zero write", 64'd1 << v);
      wr_reg(v < 32 ? 3'd4 : 3'd5, 32'd1 << (v % 32));
      pend_is("R6 clear", 64'd0);
    end

    // R3 every address bit flipped
    for (int b = 0; b < 64; b++) begin
      send(BASE ^ (64'd1 << b), 32'd5);
      pend_is("R3 mismatch", 64'd0);
    end

    // R4 enable combinations
    wr_reg(3'd1, 32'h0000_0001); send(BASE, 32'd9);  pend_is("R4 report off", 64'd0);
    wr_reg(3'd1, 32'h0000_8000); send(BASE, 32'd40); pend_is("R4 capture off", 64'd0);
    wr_reg(3'd1, 32'h0000_0000); send(BASE, 32'd1);  pend_is("R4 both off", 64'd0);
    wr_reg(3'd1, 32'h0000_8001);

    // R5 out-of-range data
    send(BASE, 32'd64);         pend_is("R5 data 64", 64'd0);
    send(BASE, 32'd65);         pend_is("R5 data 65", 64'd0);
    send(BASE, 32'h8000_0003);  pend_is("R5 high data", 64'd0);
    send(BASE, 32'd255);        pend_is("R5 data 255", 64'd0);

    // R8 masking keeps pending
    send(BASE, 32'd3);
    send(BASE, 32'd40);
    wr_reg(3'd6, 32'd0);
    chk("R8 irq_lo masked", {31'd0, irq_lo}, 32'd0);
    chk("R8 irq_hi open", {31'd0, irq_hi}, 32'd1);
    pend_is("R8 pending kept", (64'd1 << 40) | 64'd8);
    wr_reg(3'd7, 32'd0);
    chk("R8 irq_hi masked", {31'd0, irq_hi}, 32'd0);
    pend_is("R8 pending kept hi", (64'd1 << 40) | 64'd8);

    // R7 single-bit mask sweep
    for (int m = 0; m < 32; m++) begin
      wr_reg(3'd6, 32'd1 << m);
      chk("R7 mask sweep lo", {31'd0, irq_lo}, {31'd0, m == 3});
      wr_reg(3'd7, 32'd1 << m);
      chk("R7 mask sweep hi", {31'd0, irq_hi}, {31'd0, m == 8});
    end

    // R9 capture and clear together
    wr_reg(3'd5, 32'hFFFF_FFFF);
    wr_reg(3'd4, 32'hFFFF_FFFF);
    pend_is("R9 setup", 64'd0);
    send(BASE, 32'd7);
    step(1'b1, BASE, 32'd7, 1'b1, 3'd4, 32'd1 << 7);
    pend_is("R9 same bit", 64'd1 << 7);
    step(1'b1, BASE, 32'd8, 1'b1, 3'd4, 32'd1 << 7);
    pend_is("R9 other bit", 64'd1 << 8);
    step(1'b1, BASE, 32'd33, 1'b1, 3'd5, 32'd1 << 1);
    pend_is("R9 same bit hi", (64'd1 << 33) | (64'd1 << 8));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule